// File: doc/BRIEF.md
# Serial EEPROM Command Master (three-wire, 64 x 16)

This block drives a bit-serial three-wire EEPROM that holds 64 words of 16 bits. On the memory side it owns chip select, the serial clock and the serial data line into the memory, and it samples the data line that comes back. On the host side it takes a one-cycle request with a command code, a word address and, for writes, a data word. It answers with a one-cycle `done` pulse, or an `err` pulse when a write never completes. Read data is presented on `rd_data` together with `done`.

Every frame opens with a dummy zero and a start bit, then a two-bit opcode and the address. The slowest step of a write is the memory's internal programming. After the data frame the block reopens chip select and samples the return line once per clock phase until the memory reports ready, or until a fixed number of samples has passed. A write request is bracketed on its own: an enable frame goes out before it and a disable frame after it, so the memory is never left writable. The serial clock rate is set by the number of system clocks per bit phase.

Top module: `mw_eeprom_master`

## Requirements
- R1: After a synchronous reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `err` are all low.
- R2: Command codes are 00 read, 01 write, 10 write-enable and 11 write-disable. A request is taken only while `busy` is low, including the cycle in which `done` or `err` pulses. `busy` is high from the next cycle until the cycle of the `done` or `err` pulse, where it is low again. Requests made while `busy` is high have no effect.
- R3: Every frame raises `ee_cs` with `ee_sk` low, then shifts a 0, then a 1, then a two-bit opcode and then a 6-bit address, both MSB first.
- R4: A read uses opcode 10. After the address the block gives 16 more clocks and shifts the sampled return bits in MSB first. The word appears on `rd_data` in the cycle `done` pulses.
- R5: A write uses opcode 01 and shifts the 16 data bits MSB first after the address.
- R6: Write-enable is sent as opcode 00 with address 110000. Write-disable is opcode 00 with address 000000. A write request is sent as enable, write, disable, in that order.
- R7: Each bit takes three phases of `DIV` clocks each. `ee_di` is set while `ee_sk` is low, then `ee_sk` is high with `ee_di` unchanged, then `ee_sk` is low again. Return bits are sampled at the end of the high phase.
- R8: After a write frame, `ee_cs` is low for one phase and then high again. The return line is sampled once per phase, and the first 1 ends the wait. The write then finishes with `done`.
- R9: If `POLL_LIMIT` samples all read 0, the wait ends anyway. The disable frame is still sent, and the request ends with `err` instead of `done`. `done` and `err` never pulse together.
- R10: `ee_cs` is low for at least one phase between frames and between commands. `ee_sk` stays low whenever `ee_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle command request |
| req_cmd | input | 2 | Command code (R2) |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Data word for writes |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle write timeout pulse |
| rd_data | output | 16 | Word returned by the last read |
| ee_cs | output | 1 | Memory chip select, active high |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_di | output | 1 | Serial data into the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The completion pulse of one command and the acceptance of the next can fall in the same clock cycle. `busy` drops in the cycle that `done` is high, so a request held during that cycle must be taken at once. The bench waits for `done`, raises a new read request in that same cycle, and then expects `busy` high one cycle later, `done` back low, and the correct word at the end of the new read. The timeout limit and a memory that turns ready are also judged apart: a memory that never turns ready must give `err` only after the full count of samples, and the disable frame must still be sent.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_WREN  = 2'b10,
    CMD_WRDIS = 2'b11
  } mw_cmd_e;

  typedef enum logic [1:0] {B_IDLE, B_SET, B_HIGH, B_LOW} mw_bit_e;

  typedef enum logic [2:0] {Q_IDLE, Q_WAIT, Q_FRAME, Q_GAP, Q_POLL} mw_seq_e;

  typedef enum logic [1:0] {N_FRAME, N_POLL, N_FIN} mw_next_e;
endpackage

// File: rtl/mw_phase_tick.sv
module mw_phase_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/mw_bit_shifter.sv
module mw_bit_shifter
  import mw_pkg::*;
#(
  parameter int FRM_W  = 26,
  parameter int DATA_W = 16,
  parameter int IW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [FRM_W-1:0]  frm_bits,
  input  logic [IW-1:0]     n_out,
  input  logic [IW-1:0]     n_tot,
  input  logic              so,
  output logic              sk,
  output logic              di,
  output logic              fin,
  output logic [DATA_W-1:0] rx
);
  mw_bit_e          st;
  logic [FRM_W-1:0] sreg;
  logic [IW-1:0]    idx;

  assign di  = sreg[FRM_W-1];
  assign fin = tick && (st == B_LOW) && (idx == n_tot - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= B_IDLE;
      sreg <= '0;
      idx  <= '0;
      sk   <= 1'b0;
      rx   <= '0;
    end else begin
      case (st)
        B_IDLE: if (start) begin
          sreg <= frm_bits;
          idx  <= '0;
          rx   <= '0;
          st   <= B_SET;
        end
        B_SET: if (tick) begin
          sk <= 1'b1;
          st <= B_HIGH;
        end
        B_HIGH: if (tick) begin
          sk <= 1'b0;
          st <= B_LOW;
          if (idx >= n_out) rx <= {rx[DATA_W-2:0], so};
        end
        B_LOW: if (tick) begin
          if (fin) begin
            sreg <= '0;
            st   <= B_IDLE;
          end else begin
            idx  <= idx + 1'b1;
            sreg <= {sreg[FRM_W-2:0], 1'b0};
            st   <= B_SET;
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  AST_DI_HELD_SK_HIGH: assert property (@(posedge clk) disable iff (rst)
    sk |-> $stable(di)); // R7
  AST_SK_RISES_FROM_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(sk) |-> $past(st) == B_SET); // R7
endmodule

// File: rtl/mw_sequencer.sv
module mw_sequencer
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int FRM_W      = 26,
  parameter int IW         = 5,
  parameter int POLL_LIMIT = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              so,
  input  logic              fin,
  input  logic [DATA_W-1:0] rx,
  output logic              start,
  output logic [FRM_W-1:0]  frm_bits,
  output logic [IW-1:0]     n_out,
  output logic [IW-1:0]     n_tot,
  output logic              cs,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HDR_W = 4 + ADDR_W;
  localparam int PW    = $clog2(POLL_LIMIT + 1);
  localparam logic [ADDR_W-1:0] WEN_ADDR = {2'b11, {(ADDR_W-2){1'b0}}};

  mw_seq_e           st;
  mw_next_e          nxt;
  mw_cmd_e           kind;
  mw_cmd_e           cmd_in;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_flow;
  logic              is_rd;
  logic              tmo;
  logic [PW-1:0]     pcnt;
  logic [1:0]        op;
  logic [ADDR_W-1:0] fa;

  assign cmd_in = mw_cmd_e'(req_cmd);
  assign start  = tick && ((st == Q_WAIT) || ((st == Q_GAP) && (nxt == N_FRAME)));

  always_comb begin
    case (kind)
      CMD_READ:  begin op = 2'b10; fa = addr_q;   end
      CMD_WRITE: begin op = 2'b01; fa = addr_q;   end
      CMD_WREN:  begin op = 2'b00; fa = WEN_ADDR; end
      default:   begin op = 2'b00; fa = '0;       end
    endcase
    frm_bits = {1'b0, 1'b1, op, fa, (kind == CMD_WRITE) ? data_q : {DATA_W{1'b0}}};
    n_out    = (kind == CMD_WRITE) ? IW'(FRM_W) : IW'(HDR_W);
    n_tot    = (kind == CMD_WRITE || kind == CMD_READ) ? IW'(FRM_W) : IW'(HDR_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= Q_IDLE;
      nxt     <= N_FIN;
      kind    <= CMD_READ;
      addr_q  <= '0;
      data_q  <= '0;
      wr_flow <= 1'b0;
      is_rd   <= 1'b0;
      tmo     <= 1'b0;
      pcnt    <= '0;
      cs      <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        Q_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          data_q  <= req_wdata;
          wr_flow <= (cmd_in == CMD_WRITE);
          is_rd   <= (cmd_in == CMD_READ);
          kind    <= (cmd_in == CMD_WRITE) ? CMD_WREN : cmd_in;
          tmo     <= 1'b0;
          busy    <= 1'b1;
          st      <= Q_WAIT;
        end
        Q_WAIT: if (tick) begin
          cs <= 1'b1;
          st <= Q_FRAME;
        end
        Q_FRAME: if (fin) begin
          cs <= 1'b0;
          st <= Q_GAP;
          case (kind)
            CMD_WREN: begin
              if (wr_flow) begin
                kind <= CMD_WRITE;
                nxt  <= N_FRAME;
              end else begin
                nxt  <= N_FIN;
              end
            end
            CMD_WRITE: nxt <= N_POLL;
            default:   nxt <= N_FIN;
          endcase
        end
        Q_GAP: if (tick) begin
          case (nxt)
            N_FRAME: begin
              cs <= 1'b1;
              st <= Q_FRAME;
            end
            N_POLL: begin
              cs   <= 1'b1;
              pcnt <= '0;
              st   <= Q_POLL;
            end
            default: begin
              busy <= 1'b0;
              done <= !tmo;
              err  <= tmo;
              if (is_rd) rd_data <= rx;
              st   <= Q_IDLE;
            end
          endcase
        end
        Q_POLL: if (tick) begin
          if (so || (pcnt == PW'(POLL_LIMIT - 1))) begin
            tmo  <= !so;
            cs   <= 1'b0;
            kind <= CMD_WRDIS;
            nxt  <= N_FRAME;
            st   <= Q_GAP;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: st <= Q_IDLE;
      endcase
    end
  end

  AST_REQ_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> ($stable(addr_q) && $stable(data_q))); // R2
  AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !busy); // R2
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, err})); // R9
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st == Q_POLL) |-> (pcnt < PW'(POLL_LIMIT))); // R9
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master #(
  parameter int DIV        = 4,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int POLL_LIMIT = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int HDR_W = 4 + ADDR_W;
  localparam int FRM_W = HDR_W + DATA_W;
  localparam int IW    = $clog2(FRM_W + 1);

  logic              tick;
  logic              start;
  logic              fin;
  logic [FRM_W-1:0]  frm_bits;
  logic [IW-1:0]     n_out;
  logic [IW-1:0]     n_tot;
  logic [DATA_W-1:0] rx;

  mw_phase_tick #(.DIV(DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  mw_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRM_W(FRM_W), .IW(IW), .POLL_LIMIT(POLL_LIMIT)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .req_valid(req_valid),
    .req_cmd  (req_cmd),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .so       (ee_do),
    .fin      (fin),
    .rx       (rx),
    .start    (start),
    .frm_bits (frm_bits),
    .n_out    (n_out),
    .n_tot    (n_tot),
    .cs       (ee_cs),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .rd_data  (rd_data)
  );

  mw_bit_shifter #(.FRM_W(FRM_W), .DATA_W(DATA_W), .IW(IW)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .start   (start),
    .frm_bits(frm_bits),
    .n_out   (n_out),
    .n_tot   (n_tot),
    .so      (ee_do),
    .sk      (ee_sk),
    .di      (ee_di),
    .fin     (fin),
    .rx      (rx)
  );

  AST_SK_QUIET_CS_LOW: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sk); // R10
  AST_CS_RISE_SK_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> !ee_sk); // R3
endmodule

// File: tb/mw_eeprom_master_tb.sv
module mw_eeprom_master_tb;
  localparam int DIV   = 2;
  localparam int LIMIT = 10000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_cmd = 2'b00;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, err, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] rd_data;

  always #10 clk = ~clk;

  mw_eeprom_master #(.DIV(DIV), .POLL_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rd_data(rd_data), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do)
  );

  function automatic logic [15:0] pre(input int a);
    return 16'hC000 ^ 16'(a * 257);
  endfunction

  // ---------------- memory model ----------------
  logic [15:0] mem [64];
  bit          mem_v [64];
  bit          we, pend, polling, rd_bit, m_cs, m_sk;
  int          bitc, nlog, nwr, ncs, hdr_bad, gap_bad, ready_at, model_busy;
  logic [25:0] sh;
  logic [1:0]  mop;
  logic [5:0]  maddr;
  logic [2:0]  lg [16];
  int          clk_cnt, gap_cnt, hi_cnt, timing_bad, di_bad;
  bit          seen_fall, cs_p, sk_p;

  assign ee_do = polling ? (clk_cnt >= ready_at) : rd_bit;

  always @(ee_cs or ee_sk) begin
    if (ee_cs && !m_cs) begin
      bitc = 0; sh = '0; ncs++;
      if (pend) polling = 1'b1;
    end
    if (!ee_cs && m_cs) begin
      rd_bit = 1'b0;
      if (polling) begin polling = 1'b0; pend = 1'b0; end
    end
    if (ee_sk && !m_sk && !ee_cs) gap_bad++;
    if (ee_sk && !m_sk && ee_cs && !polling) begin
      sh = {sh[24:0], ee_di};
      bitc++;
      if (bitc == 10) begin
        if (sh[9] !== 1'b0 || sh[8] !== 1'b1) hdr_bad++;
        mop = sh[7:6]; maddr = sh[5:0];
        if (mop == 2'b10) lg[nlog % 16] = 3'd0;
        else if (mop == 2'b01) lg[nlog % 16] = 3'd1;
        else if (mop == 2'b00 && maddr == 6'b110000) begin lg[nlog % 16] = 3'd2; we = 1'b1; end
        else if (mop == 2'b00 && maddr == 6'b000000) begin lg[nlog % 16] = 3'd3; we = 1'b0; end
        else lg[nlog % 16] = 3'd4;
        nlog++;
      end
      if (mop == 2'b10 && bitc >= 11 && bitc <= 26)
        rd_bit = mem_v[maddr] ? mem[maddr][26-bitc] : pre(int'(maddr))[26-bitc];
      if (mop == 2'b01 && bitc == 26 && we) begin
        mem[maddr] = sh[15:0]; mem_v[maddr] = 1'b1; nwr++;
        pend = 1'b1; ready_at = clk_cnt + model_busy;
      end
    end
    m_cs = ee_cs; m_sk = ee_sk;
  end

  always @(ee_di) if (ee_sk) di_bad++;

  always @(negedge clk) begin
    clk_cnt++;
    if (ee_sk) hi_cnt++;
    else if (sk_p) begin
      if (hi_cnt != DIV) timing_bad++;
      hi_cnt = 0;
    end
    if (!ee_cs) gap_cnt++;
    if (!ee_cs && cs_p) seen_fall = 1'b1;
    if (ee_cs && !cs_p) begin
      if (seen_fall && gap_cnt < DIV) gap_bad++;
      gap_cnt = 0;
    end
    cs_p = ee_cs; sk_p = ee_sk;
  end

  // ---------------- checking ----------------
  int nchk = 0, nerr = 0;
  bit t_done, t_err;
  logic [15:0] t_rd;
  int t_cyc;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] c, input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    t_cyc = 0;
    while (!(done || err) && t_cyc < 60000) begin @(negedge clk); t_cyc++; end
    t_done = done; t_err = err; t_rd = rd_data;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr + 1);
      $finish;
    end
  end

  // write/read vectors: {addr, data}
  localparam logic [21:0] VEC [6] = '{
    {6'd0,  16'hA55A}, {6'd63, 16'h0001}, {6'd21, 16'hFFFF},
    {6'd42, 16'h0000}, {6'd1,  16'h8000}, {6'd33, 16'h1234}
  };

  initial begin
    int l0, c0, w0;
    model_busy = 5;
    repeat (3) @(negedge clk);
    chk("R1 cs", ee_cs, 0); chk("R1 sk", ee_sk, 0); chk("R1 di", ee_di, 0);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
    rst = 1'b0;

    // R4 read of unwritten word
    l0 = nlog;
    do_cmd(2'b00, 6'd5, 16'h0);
    chk("R4 read preload", t_rd, pre(5));
    chk("R4 read done", t_done, 1);
    chk("R3 read opcode log", lg[l0 % 16], 0);

    for (int i = 0; i < 6; i++) begin
      logic [5:0] a; logic [15:0] d;
      a = VEC[i][21:16]; d = VEC[i][15:0];
      l0 = nlog; c0 = ncs;
      do_cmd(2'b01, a, d);
      chk("R8 write done", {t_done, t_err}, 2'b10);
      chk("R5 stored word", mem[a], d);
      chk("R6 order enable", lg[l0 % 16], 2);
      chk("R6 order write", lg[(l0 + 1) % 16], 1);
      chk("R6 order disable", lg[(l0 + 2) % 16], 3);
      chk("R8 cs openings", ncs - c0, 4);
      chk("R6 left protected", we, 0);
      do_cmd(2'b00, a, 16'h0);
      chk("R4 readback", t_rd, d);
    end

    // R6 standalone enable / disable
    do_cmd(2'b10, 6'd9, 16'h0);
    chk("R6 enable alone", we, 1);
    do_cmd(2'b11, 6'd9, 16'h0);
    chk("R6 disable alone", we, 0);

    // R8 memory ready at first sample
    model_busy = 0;
    do_cmd(2'b01, 6'd12, 16'h5AA5);
    chk("R8 ready at once", {t_done, t_err}, 2'b10);
    model_busy = 5;

    // R2 request while busy is ignored
    w0 = nwr;
    @(negedge clk); while (busy) @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'b00; req_addr = 6'd10;
    @(negedge clk); req_valid = 1'b0;
    chk("R2 busy after accept", busy, 1);
    repeat (20) @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'b01; req_addr = 6'd10; req_wdata = 16'h0;
    @(negedge clk); req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk("R2 read under stray request", rd_data, pre(10));
    // R2 same-cycle: new request during the done cycle
    chk("R2 busy low with done", busy, 0);
    req_valid = 1'b1; req_cmd = 2'b00; req_addr = 6'd0;
    @(negedge clk); req_valid = 1'b0;
    chk("R2 accepted in done cycle", {busy, done}, 2'b10);
    while (!done) @(negedge clk);
    chk("R2 back-to-back read", rd_data, 16'hA55A);
    repeat (200) @(negedge clk);
    chk("R2 stray write dropped", nwr - w0, 0);
    chk("R2 word untouched", mem_v[10], 0);

    // R9 memory never ready
    model_busy = 1000000;
    l0 = nlog;
    do_cmd(2'b01, 6'd7, 16'hBEEF);
    chk("R9 error pulse", {t_done, t_err}, 2'b01);
    chk("R9 full wait", t_cyc >= LIMIT * DIV, 1);
    chk("R9 bounded wait", t_cyc < LIMIT * DIV + 600, 1);
    chk("R9 disable still sent", lg[(l0 + 2) % 16], 3);
    model_busy = 5;
    repeat (5) @(negedge clk);
    chk("R9 busy released", busy, 0);

    chk("R3 frame prefix", hdr_bad, 0);
    chk("R7 high phase width", timing_bad, 0);
    chk("R7 data held while clock high", di_bad, 0);
    chk("R10 gaps and quiet clock", gap_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule